// File: doc/BRIEF.md
# Threshold Alert Latch with Alert-Response Arbitration

This block watches the stream of finished conversion results of a converter-style I2C target and raises an open-drain alert line whenever a result leaves a programmable signed window. In latching mode the alert stays asserted until software reads the conversion data or until a bus controller collects it through an SMBus Alert Response Address read. In non-latching mode the alert simply reflects the most recent result.

During an alert response read the block decodes the command byte `0x19` (address `0001100`, read bit set) from the raw SCL and SDA lines. It acknowledges the byte only while its alert is latched, and then shifts out its own 7-bit address followed by one status bit on open-drain SDA. It compares every released bit with the bus level. If it releases SDA for a 1 and the bus reads 0, a device with a lower address is also answering: this block withdraws and keeps its alert. Only a block that completes the whole byte clears its latch, once the controller's acknowledge slot has been clocked.

The responder state machine has seven states:
- `R_IDLE` waits for a START.
- `R_CMD` shifts in the command byte. After eight bits it moves to `R_ACK_WAIT` on a match while armed, and to `R_WAIT` otherwise.
- `R_ACK_WAIT` pulls SDA low at the next SCL fall and moves to `R_ACK`.
- `R_ACK` loads the reply byte at the following fall and moves to `R_SEND`.
- `R_SEND` drives bits on falls and checks them on rises. A lost bit sends it to `R_WAIT`. After the eighth bit it releases SDA at the next fall and moves to `R_HACK`.
- `R_HACK` issues the win pulse on the ninth rise and moves to `R_WAIT`.
- `R_WAIT` ignores traffic until the next START (which goes to `R_CMD`) or the next STOP (which goes to `R_IDLE`).

A START from any state goes to `R_CMD`, and a STOP from any state goes to `R_IDLE`.

Top module: `arp_alert_top`

## Requirements
- R1: With `alert_en`=1 and `latch_mode`=1, a `conv_valid` pulse whose data is out of range sets the latch, and `alert_drive_low` is 1 from the next clock on.
- R2: Once latched, the alert stays asserted through later in-range conversions until a clear occurs.
- R3: A `data_read` pulse clears the latch on the next clock. A later out-of-range conversion sets it again. If a set and a `data_read` arrive in the same cycle, the set wins.
- R4: With `alert_en`=0, `alert_drive_low` is 0 whatever the results. The block also does not answer an alert response while disabled.
- R5: With `latch_mode`=0, `alert_drive_low` follows the range result of the most recent conversion.
- R6: Data and both thresholds are signed two's complement. A result is out of range when it is strictly greater than `thr_hi`, or, only when `window_mode`=1, strictly less than `thr_lo`. Equality never triggers.
- R7: The block acknowledges the command byte 0x19 (driving SDA low in the ninth clock) only while `alert_en`, `latch_mode` and the latch are all 1. Any other byte, or an unarmed block, leaves SDA released for the whole transfer.
- R8: The reply byte is `dev_addr[6:0]` MSB first, followed by the status bit, sent open-drain. Bits change only while SCL is low.
- R9: If the block releases SDA for a 1 and samples the bus low, it stops driving for the rest of the transfer and its latch stays set.
- R10: A block that sends all eight reply bits without losing clears its latch when SCL rises for the controller's acknowledge slot.
- R11: The status bit is 1 if the conversion that set the latch was above `thr_hi` and 0 otherwise. It is captured when the latch sets and does not change until the latch has cleared.
- R12: SCL and SDA pass through a two-flop synchroniser and an agreement filter. `sda_drive_low` never changes while the filtered SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data | input | 12 | Signed result of the finished conversion |
| thr_hi | input | 12 | Signed upper threshold |
| thr_lo | input | 12 | Signed lower threshold |
| alert_en | input | 1 | Enables the alert function |
| latch_mode | input | 1 | 1 = latching alert, 0 = alert follows the last result |
| window_mode | input | 1 | 1 = lower threshold also checked |
| dev_addr | input | 7 | This target's 7-bit bus address |
| data_read | input | 1 | One-cycle strobe: conversion data was read |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain) |
| alert_drive_low | output | 1 | 1 = pull the alert line low (open-drain) |

## Verification
The bench models the alert latch for every clock and drives a complete alert response read. It adds a second responder on the wired-AND SDA line whose address is either lower or higher than the block's own. If the loss test were missing, or if the block cleared its latch on a loss, the byte the controller reads would be corrupted or the alert would vanish after a lost round. If the latch cleared on the acknowledge of the command rather than after the whole byte, the state after a lost round would also be wrong. Other boundary cases are a result exactly equal to either threshold, the most negative code, a set and a data read in the same cycle, a status bit that must stay frozen when a later result crosses the other limit, and command bytes sent to an unarmed or disabled block. Each of these shows up either as a wrong level on the alert line or as a wrong byte or acknowledge on SDA.

// File: rtl/arp_pkg.sv
package arp_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam logic [7:0] ARA_CMD = 8'h19;

    typedef enum logic [2:0] {
        R_IDLE,
        R_CMD,
        R_ACK_WAIT,
        R_ACK,
        R_SEND,
        R_HACK,
        R_WAIT
    } rsp_state_t;
endpackage

// File: rtl/arp_line_sync.sv
module arp_line_sync #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0]   sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            q      <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], d};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[STAGES-1]};
            if (&hist_q)
                q <= 1'b1;
            else if (~|hist_q)
                q <= 1'b0;
        end
    end
endmodule

// File: rtl/arp_compare.sv
module arp_compare #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    input  logic              window,
    output logic              over_hi,
    output logic              out_of_range
);
    logic under_lo;

    always_comb begin
        over_hi      = $signed(data) > $signed(hi_lim);
        under_lo     = $signed(data) < $signed(lo_lim);
        out_of_range = over_hi | (window & under_lo);
    end
endmodule

// File: rtl/arp_responder.sv
module arp_responder
    import arp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              armed,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic              status_bit,
    output logic              sda_low,
    output logic              win
);
    localparam int CW = $clog2(BYTE_W + 1);

    rsp_state_t        state_q, state_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [BYTE_W-1:0] shift_q, shift_n;
    logic              drv_q, drv_n;
    logic              win_q, win_n;
    logic              scl_d, sda_d;
    logic              scl_rise, scl_fall, start_c, stop_c;
    logic [BYTE_W-1:0] rx_byte;

    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;
    assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
    assign rx_byte  = {shift_q[BYTE_W-2:0], sda_f};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            drv_q   <= 1'b0;
            win_q   <= 1'b0;
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            shift_q <= shift_n;
            drv_q   <= drv_n;
            win_q   <= win_n;
            scl_d   <= scl_f;
            sda_d   <= sda_f;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        shift_n = shift_q;
        drv_n   = drv_q;
        win_n   = 1'b0;
        if (start_c) begin
            state_n = R_CMD;
            cnt_n   = '0;
            drv_n   = 1'b0;
        end else if (stop_c) begin
            state_n = R_IDLE;
            drv_n   = 1'b0;
        end else begin
            unique case (state_q)
                R_IDLE, R_WAIT: ;
                R_CMD: if (scl_rise) begin
                    shift_n = rx_byte;
                    cnt_n   = cnt_q + 1'b1;
                    if (cnt_q == CW'(BYTE_W - 1))
                        state_n = (rx_byte == ARA_CMD && armed) ? R_ACK_WAIT : R_WAIT;
                end
                R_ACK_WAIT: if (scl_fall) begin
                    drv_n   = 1'b1;
                    state_n = R_ACK;
                end
                R_ACK: if (scl_fall) begin
                    shift_n = {my_addr, status_bit};
                    drv_n   = ~my_addr[ADDR_W-1];
                    cnt_n   = '0;
                    state_n = R_SEND;
                end
                R_SEND: begin
                    if (scl_rise) begin
                        if (!drv_q && !sda_f)
                            state_n = R_WAIT;
                        else
                            cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == CW'(BYTE_W)) begin
                            drv_n   = 1'b0;
                            state_n = R_HACK;
                        end else begin
                            drv_n   = ~shift_q[BYTE_W-2];
                            shift_n = {shift_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                R_HACK: if (scl_rise) begin
                    win_n   = 1'b1;
                    state_n = R_WAIT;
                end
                default: state_n = R_IDLE;
            endcase
        end
    end

    assign sda_low = drv_q;
    assign win     = win_q;

    assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drv_q) |-> !$past(scl_f));

    assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_IDLE || state_q == R_CMD) |-> !drv_q);

    assert_loss_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_SEND && scl_rise && !drv_q && !sda_f && !start_c && !stop_c)
        |=> (state_q == R_WAIT && !drv_q));
endmodule

// File: rtl/arp_alert_top.sv
module arp_alert_top
    import arp_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic              alert_en,
    input  logic              latch_mode,
    input  logic              window_mode,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              data_read,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic              alert_drive_low
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic over_hi, oor, win, set, clr, armed;
    logic lat_q, status_q, cmp_q;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        arp_line_sync #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_lines[g]),
            .q    (filt_lines[g])
        );
    end

    arp_compare #(.DATA_W(DATA_W)) u_cmp (
        .data        (conv_data),
        .hi_lim      (thr_hi),
        .lo_lim      (thr_lo),
        .window      (window_mode),
        .over_hi     (over_hi),
        .out_of_range(oor)
    );

    assign set   = conv_valid & oor & latch_mode & alert_en;
    assign clr   = data_read | win;
    assign armed = alert_en & latch_mode & lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q    <= 1'b0;
            status_q <= 1'b0;
            cmp_q    <= 1'b0;
        end else begin
            if (conv_valid)
                cmp_q <= oor;
            if (set) begin
                lat_q <= 1'b1;
                if (!lat_q || clr)
                    status_q <= over_hi;
            end else if (clr) begin
                lat_q <= 1'b0;
            end
        end
    end

    arp_responder u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_lines[0]),
        .sda_f     (filt_lines[1]),
        .armed     (armed),
        .my_addr   (dev_addr),
        .status_bit(status_q),
        .sda_low   (sda_drive_low),
        .win       (win)
    );

    assign alert_drive_low = alert_en & (latch_mode ? lat_q : cmp_q);

    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && oor && latch_mode && alert_en) |=> lat_q);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !data_read && !win) |=> lat_q);

    assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read && !set) |=> !lat_q);

    assert_win_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !set) |=> !lat_q);

    assert_status_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !clr) |=> $stable(status_q));
endmodule

// File: tb/arp_alert_top_tb_top.sv
`timescale 1ns/1ps
module arp_alert_top_tb_top;
    localparam int H = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        conv_valid = 1'b0, data_read = 1'b0;
    logic [11:0] conv_data = '0, thr_hi = 12'd100, thr_lo = 12'hF9C;
    logic        alert_en = 1'b1, latch_mode = 1'b1, window_mode = 1'b1;
    logic [6:0]  dev_addr = 7'h48;
    logic        scl_c = 1'b1, sda_c = 1'b1, riv_sda = 1'b1;
    logic        sda_drive_low, alert_drive_low;
    wire         sda_bus = sda_c & riv_sda & ~sda_drive_low;

    int n_chk = 0, n_fail = 0, r12_bad = 0;
    bit cmp_en = 0, clr_req = 0, done = 0;
    bit m_lat = 0, m_stat = 0, m_cmp = 0;

    always #2 clk = ~clk;

    arp_alert_top dut_i (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .alert_en(alert_en), .latch_mode(latch_mode),
        .window_mode(window_mode), .dev_addr(dev_addr), .data_read(data_read),
        .scl_in(scl_c), .sda_in(sda_bus), .sda_drive_low(sda_drive_low),
        .alert_drive_low(alert_drive_low)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference of the alert latch (R1, R2, R3, R5, R6, R11)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat <= 0; m_stat <= 0; m_cmp <= 0;
        end else begin
            int d, hi, lo;
            bit above, outr;
            d  = int'($signed(conv_data));
            hi = int'($signed(thr_hi));
            lo = int'($signed(thr_lo));
            above = d > hi;
            outr  = above || (window_mode && d < lo);
            if (conv_valid) m_cmp <= outr;
            if (conv_valid && outr && latch_mode && alert_en) begin
                if (!m_lat || data_read) m_stat <= above;
                m_lat <= 1;
            end else if (data_read || clr_req) begin
                m_lat <= 0;
            end
        end
    end

    logic prev_drv = 1'b0, prev_scl = 1'b1;
    always @(negedge clk) begin
        if (cmp_en)
            chk("R1", alert_drive_low, alert_en & (latch_mode ? m_lat : m_cmp), "alert pin vs model");
        if (rst_n && scl_c && prev_scl && (sda_drive_low != prev_drv)) r12_bad++;
        prev_drv = sda_drive_low;
        prev_scl = scl_c;
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic conv(input int d);
        @(negedge clk); conv_data = 12'(d); conv_valid = 1;
        @(negedge clk); conv_valid = 0;
        wcyc(1);
    endtask

    task automatic rd();
        @(negedge clk); data_read = 1;
        @(negedge clk); data_read = 0;
        wcyc(1);
    endtask

    task automatic ara(input string req, input logic [7:0] cmd, input bit riv_on,
                       input logic [6:0] riv_addr, input bit riv_stat);
        logic [7:0] got, exp_got, db, rb;
        bit ack, dut_act, ract, exp_ack, b;
        dut_act = (cmd == 8'h19) && alert_en && latch_mode && m_lat;
        exp_ack = dut_act;
        db = {dev_addr, m_stat};
        rb = {riv_addr, riv_stat};
        ract = riv_on;
        cmp_en = 0;
        @(negedge clk);
        sda_c = 1; scl_c = 1; wcyc(H); sda_c = 0; wcyc(H); scl_c = 0; wcyc(4);
        for (int i = 7; i >= 0; i--) begin
            sda_c = cmd[i]; wcyc(H); scl_c = 1; wcyc(H); scl_c = 0; wcyc(4);
        end
        sda_c = 1; riv_sda = riv_on ? 1'b0 : 1'b1;
        wcyc(H); scl_c = 1; wcyc(H/2); ack = !sda_bus; wcyc(H/2); scl_c = 0; wcyc(4);
        for (int i = 7; i >= 0; i--) begin
            riv_sda = ract ? rb[i] : 1'b1;
            wcyc(H); scl_c = 1; wcyc(H/2);
            got[i] = sda_bus;
            b = 1;
            if (dut_act) b = b & db[i];
            if (ract) b = b & rb[i];
            exp_got[i] = b;
            if (dut_act && db[i] && !b) dut_act = 0;
            if (ract && rb[i] && !b) ract = 0;
            wcyc(H/2); scl_c = 0; wcyc(4);
        end
        riv_sda = 1; sda_c = 1;
        wcyc(H); scl_c = 1; wcyc(H); scl_c = 0; wcyc(H);
        sda_c = 0; wcyc(H); scl_c = 1; wcyc(H); sda_c = 1; wcyc(2*H);
        chk(req, got, exp_got, "reply byte on SDA");
        if (!riv_on) chk("R7", ack, exp_ack, "command acknowledge");
        if (dut_act) begin
            @(negedge clk); clr_req = 1; @(negedge clk); clr_req = 0;
        end
        cmp_en = 1;
        wcyc(1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        wcyc(5);
        rst_n = 1;
        wcyc(1);
        chk("R1", alert_drive_low, 0, "alert after reset");
        chk("R7", sda_drive_low, 0, "SDA after reset");
        cmp_en = 1;
        // R6: equality never triggers
        conv(100);  chk("R6", alert_drive_low, 0, "equal to upper limit");
        conv(-100); chk("R6", alert_drive_low, 0, "equal to lower limit");
        conv(101);  chk("R1", alert_drive_low, 1, "above upper limit latches");
        conv(0);    chk("R2", alert_drive_low, 1, "held after in-range result");
        rd();       chk("R3", alert_drive_low, 0, "cleared by data read");
        conv(0);    chk("R3", alert_drive_low, 0, "stays clear in range");
        conv(-101); chk("R3", alert_drive_low, 1, "re-asserts after clear");
        // R11 status 0 from low crossing; R8 reply byte; R10 cleared on win
        ara("R8", 8'h19, 0, 7'h0, 0);
        chk("R10", alert_drive_low, 0, "cleared after won response");
        conv(-2048); chk("R6", alert_drive_low, 1, "most negative code below limit");
        rd();
        conv(2047);  conv(-2048);   // status must stay 1 (R11)
        ara("R11", 8'h19, 0, 7'h0, 0);
        chk("R10", alert_drive_low, 0, "cleared after second win");
        // R9: lower-addressed rival wins, latch kept
        conv(200);
        ara("R9", 8'h19, 1, 7'h20, 1);
        chk("R9", alert_drive_low, 1, "latch kept after lost round");
        ara("R8", 8'h19, 0, 7'h0, 0);
        chk("R10", alert_drive_low, 0, "cleared on retry");
        // higher-addressed rival loses
        conv(200);
        ara("R9", 8'h19, 1, 7'h50, 0);
        chk("R10", alert_drive_low, 0, "won against higher address");
        // R7: unarmed, and wrong command
        ara("R7", 8'h19, 0, 7'h0, 0);
        conv(200);
        ara("R7", 8'h91, 0, 7'h0, 0);
        chk("R7", alert_drive_low, 1, "wrong command keeps latch");
        // R3: set and read in the same cycle
        @(negedge clk); conv_data = 12'd300; conv_valid = 1; data_read = 1;
        @(negedge clk); conv_valid = 0; data_read = 0;
        chk("R3", alert_drive_low, 1, "set wins over simultaneous read");
        // R4: disabled releases pin and does not answer
        alert_en = 0; wcyc(1);
        chk("R4", alert_drive_low, 0, "disabled releases pin");
        ara("R4", 8'h19, 0, 7'h0, 0);
        alert_en = 1; wcyc(1);
        chk("R4", alert_drive_low, 1, "latch preserved while disabled");
        rd();
        // R5: non-latching mode
        latch_mode = 0; wcyc(1);
        conv(200); chk("R5", alert_drive_low, 1, "follows out-of-range result");
        conv(0);   chk("R5", alert_drive_low, 0, "follows in-range result");
        window_mode = 0; wcyc(1);
        conv(-500); chk("R6", alert_drive_low, 0, "lower limit ignored outside window mode");
        chk("R12", r12_bad, 0, "SDA drive changes while SCL high");
        finish_up();
    end
endmodule